// File: doc/BRIEF.md
# Early-Acknowledge Output Port Write Sequencer

This block runs the initiating side of one write to an output port that uses a four-phase handshake in which the far end raises acknowledge early. A start pulse names one of several source registers. The block opens the matching leg of the port multiplexer and waits a programmable number of settle cycles. It then raises request. The far end answers by raising acknowledge almost at once. The block then withdraws request but keeps the multiplexer leg open, because the data is still being read. When acknowledge falls, the read is complete. The block closes the multiplexer leg, waits an optional recovery time and pulses done.

The block is fully synchronous, and the settle and recovery times are counted in clock cycles. The multiplexer select is one-hot and is all zero whenever no write is using the port. Any acknowledge that arrives when the protocol cannot expect one raises a sticky error flag.

Top module: `port_write_seq`

## Requirements
- R1: After reset, the select output is all zero and request, done and error are all low. At every cycle the select has at most one bit set.
- R2: In idle, a start with a source index below N_SRC sets the select to the one-hot code with bit number equal to the index, from the next cycle on. Request stays low in that cycle.
- R3: Request rises rise_dly+1 cycles after the select appears, where rise_dly is the value present with the start. The select does not change during that time.
- R4: Request falls in the cycle after acknowledge is sampled high while request is high. The select stays unchanged.
- R5: The select stays unchanged while acknowledge remains high. It returns to all zero in the cycle after acknowledge is sampled low.
- R6: Done is a pulse one cycle wide. It appears fall_dly+1 cycles after acknowledge is sampled low, where fall_dly is the value present at that sample.
- R7: A start that arrives while a write is in progress has no effect on the select or on the timing of request.
- R8: A start in idle whose source index is N_SRC or above is ignored. The select stays zero and request stays low.
- R9: Acknowledge sampled high while idle, while settling or while recovering sets the error flag. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a write from the indexed source |
| src_idx_i | input | IDX_W | Source register index |
| ack_i | input | 1 | Acknowledge from the far end |
| rise_dly_i | input | DLY_W | Settle cycles before request, less one |
| fall_dly_i | input | DLY_W | Recovery cycles after acknowledge falls, less one |
| sel_o | output | N_SRC | One-hot multiplexer select |
| req_o | output | 1 | Request |
| done_o | output | 1 | Write complete pulse |
| err_o | output | 1 | Sticky protocol error |

## Verification
Two functions can land in the same cycle. The first is a done pulse together with a new start. The bench raises start in the very cycle that done is high, and expects the new select on the next cycle, so the release of one write and the capture of the next must not collide. The second is a stray start during the settle or hold phase. The bench fires such a start with a different index and judges it by an unchanged select and by a request edge at the cycle count of the original write. Random writes vary the index, both delays and the acknowledge hold time, and are checked against cycle counts derived from the requirements.

// File: rtl/pws_pkg.sv
package pws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETTLE  = 3'd1,
        ST_REQ     = 3'd2,
        ST_HOLD    = 3'd3,
        ST_RECOVER = 3'd4
    } pws_state_e;
endpackage

// File: rtl/pws_dly_cnt.sv
module pws_dly_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pws_sel_decode.sv
module pws_sel_decode #(
    parameter int N     = 6,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             en_i,
    output logic [N-1:0]     sel_o
);
    for (genvar g = 0; g < N; g++) begin : g_leg
        assign sel_o[g] = en_i && (int'(idx_i) == g);
    end
endmodule

// File: rtl/port_write_seq.sv
module port_write_seq
    import pws_pkg::*;
#(
    parameter int N_SRC = 6,
    parameter int DLY_W = 4,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] src_idx_i,
    input  logic             ack_i,
    input  logic [DLY_W-1:0] rise_dly_i,
    input  logic [DLY_W-1:0] fall_dly_i,
    output logic [N_SRC-1:0] sel_o,
    output logic             req_o,
    output logic             done_o,
    output logic             err_o
);
    typedef struct packed {
        pws_state_e       state;
        logic [IDX_W-1:0] idx;
        logic             req;
        logic             done;
        logic             err;
    } regs_t;

    localparam regs_t RESET_VAL = '{state: ST_IDLE, idx: '0, req: 1'b0, done: 1'b0, err: 1'b0};

    regs_t            d, q;
    logic             cnt_load;
    logic [DLY_W-1:0] cnt_val;
    logic             cnt_zero;
    logic             sel_en;

    pws_dly_cnt #(.W(DLY_W)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (cnt_load),
        .load_val_i(cnt_val),
        .zero_o    (cnt_zero)
    );

    assign sel_en = (q.state == ST_SETTLE) || (q.state == ST_REQ) || (q.state == ST_HOLD);

    pws_sel_decode #(.N(N_SRC), .IDX_W(IDX_W)) i_dec (
        .idx_i(q.idx),
        .en_i (sel_en),
        .sel_o(sel_o)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        d.err    = q.err | (ack_i && ((q.state == ST_IDLE) || (q.state == ST_SETTLE)
                                      || (q.state == ST_RECOVER)));
        case (q.state)
            ST_IDLE: begin
                if (start_i && (int'(src_idx_i) < N_SRC)) begin
                    d.state  = ST_SETTLE;
                    d.idx    = src_idx_i;
                    cnt_load = 1'b1;
                    cnt_val  = rise_dly_i;
                end
            end
            ST_SETTLE: begin
                if (cnt_zero) begin
                    d.state = ST_REQ;
                    d.req   = 1'b1;
                end
            end
            ST_REQ: begin
                if (ack_i) begin
                    d.state = ST_HOLD;
                    d.req   = 1'b0;
                end
            end
            ST_HOLD: begin
                if (!ack_i) begin
                    if (fall_dly_i == '0) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.state  = ST_RECOVER;
                        cnt_load = 1'b1;
                        cnt_val  = fall_dly_i - DLY_W'(1);
                    end
                end
            end
            ST_RECOVER: begin
                if (cnt_zero) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end
            end
            default: d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    assign req_o  = q.req;
    assign done_o = q.done;
    assign err_o  = q.err;

    a_r1_sel_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));
    a_r3_sel_before_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> ($past(sel_o) == sel_o) && (sel_o != '0));
    a_r4_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);
    a_r5_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_o != '0) && ack_i) |=> $stable(sel_o));
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r6_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sel_o == '0) && !req_o);
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

// File: tb/test_port_write_seq.sv
module test_port_write_seq;
    localparam int N_SRC = 6;
    localparam int DLY_W = 4;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [IDX_W-1:0] src_idx_i = '0;
    logic             ack_i = 1'b0;
    logic [DLY_W-1:0] rise_dly_i = '0;
    logic [DLY_W-1:0] fall_dly_i = '0;
    logic [N_SRC-1:0] sel_o;
    logic             req_o, done_o, err_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    port_write_seq #(.N_SRC(N_SRC), .DLY_W(DLY_W), .IDX_W(IDX_W)) i_port_write_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_idx_i(src_idx_i),
        .ack_i(ack_i), .rise_dly_i(rise_dly_i), .fall_dly_i(fall_dly_i),
        .sel_o(sel_o), .req_o(req_o), .done_o(done_o), .err_o(err_o)
    );

    function automatic logic [N_SRC-1:0] onehot(input int idx);
        return N_SRC'(1) << idx;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(sel_o == '0 && !req_o && !done_o && !err_o, "R1 reset state",
              int'({sel_o, req_o, done_o, err_o}), 0);
    endtask

    // full write; stray_idx >= 0 fires a busy start during settle and hold
    task automatic write_op(input int idx, input int rise, input int fall,
                            input int req_wait, input int ack_hold, input int stray_idx);
        int n;
        rise_dly_i = DLY_W'(rise);
        src_idx_i  = IDX_W'(idx);
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(sel_o == onehot(idx) && !req_o, "R2 select after start", int'(sel_o), int'(onehot(idx)));
        n = 0;
        while (!req_o && n < 40) begin
            if (stray_idx >= 0 && n == 0) begin
                src_idx_i = IDX_W'(stray_idx);
                start_i   = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            n++;
            if (!req_o)
                check(sel_o == onehot(idx), "R3 select stable in settle", int'(sel_o), int'(onehot(idx)));
        end
        check(n == rise + 1, "R3 request delay", n, rise + 1);
        if (stray_idx >= 0) check(sel_o == onehot(idx), "R7 stray start ignored", int'(sel_o), int'(onehot(idx)));
        for (int i = 0; i < req_wait; i++) begin
            @(negedge clk);
            check(req_o == 1'b1, "R4 request held until ack", int'(req_o), 1);
        end
        ack_i = 1'b1;
        @(negedge clk);
        check(!req_o, "R4 request drops after ack", int'(req_o), 0);
        check(sel_o == onehot(idx), "R4 select kept at ack", int'(sel_o), int'(onehot(idx)));
        for (int i = 0; i < ack_hold; i++) begin
            if (stray_idx >= 0 && i == 0) begin
                src_idx_i = IDX_W'(stray_idx);
                start_i   = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            check(sel_o == onehot(idx) && !req_o, "R5 R7 select held while ack high",
                  int'(sel_o), int'(onehot(idx)));
        end
        fall_dly_i = DLY_W'(fall);
        ack_i = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) check(sel_o == '0, "R5 select released", int'(sel_o), 0);
        end while (!done_o && n < 40);
        check(n == fall + 1, "R6 done delay", n, fall + 1);
        check(!err_o, "R9 no error on legal handshake", int'(err_o), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        do_reset();

        // directed corners: zero delays, highest index, stray starts
        write_op(0, 0, 0, 0, 0, -1);
        @(negedge clk);
        check(!done_o, "R6 done lasts one cycle", int'(done_o), 0);
        write_op(N_SRC - 1, 15, 15, 2, 3, 2);
        write_op(3, 2, 1, 1, 2, 1);

        // start in the same cycle as done
        rise_dly_i = 4'd1; fall_dly_i = 4'd0;
        src_idx_i = 3'd2; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (2) @(negedge clk);
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0; @(negedge clk);
        check(done_o == 1'b1, "R6 done before back-to-back start", int'(done_o), 1);
        src_idx_i = 3'd4; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check(sel_o == onehot(4), "R2 start accepted with done", int'(sel_o), int'(onehot(4)));
        repeat (2) @(negedge clk);
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
        repeat (3) @(negedge clk);

        // out-of-range index
        for (int bad = N_SRC; bad < 8; bad++) begin
            src_idx_i = IDX_W'(bad); start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            check(sel_o == '0, "R8 bad index select stays zero", int'(sel_o), 0);
            repeat (3) @(negedge clk);
            check(!req_o, "R8 bad index no request", int'(req_o), 0);
        end

        // random writes
        for (int t = 0; t < 60; t++) begin
            write_op(int'($urandom_range(N_SRC - 1)), int'($urandom_range(15)),
                     int'($urandom_range(15)), int'($urandom_range(4)),
                     int'($urandom_range(5)),
                     ($urandom_range(3) == 0) ? int'($urandom_range(N_SRC - 1)) : -1);
            repeat ($urandom_range(2)) @(negedge clk);
        end

        // spurious ack in idle
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
        check(err_o == 1'b1, "R9 error on ack in idle", int'(err_o), 1);
        repeat (3) @(negedge clk);
        check(err_o == 1'b1, "R9 error sticky", int'(err_o), 1);
        do_reset();

        // spurious ack during settle
        rise_dly_i = 4'd6; src_idx_i = 3'd1; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
        check(err_o == 1'b1, "R9 error on ack while settling", int'(err_o), 1);
        do_reset();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule